// File: doc/BRIEF.md
# Conditional PC-Relative Branch Unit

This unit resolves branch instructions for a CPU with 16-bit instruction words and a 32-bit program counter. A branch is two words long. The first word carries the opcode, a 4-bit condition selector and the top eight bits of a signed 24-bit displacement. The second word carries the remaining sixteen displacement bits. The unit compares the selector with the Carry, Overflow, Negative and Zero flags left by the latest ALU operation. It returns the program counter value to load next and a flag that says whether the branch was taken.

The base for the displacement is the address of the word that follows the two-word branch. The unit sign-extends the displacement to 32 bits and adds it to that base, wrapping modulo 2^32. When the condition fails, the returned value is the base address itself.

A subroutine call needs a store before the program counter changes. The unit saves the return address to memory at the stack-pointer address as two 16-bit writes, high half first, over a valid/ready write port. Only after the second write is acknowledged does it report the new program counter.

Top module: `branch_unit`

## Requirements
- R1: An instruction is accepted on a rising clock edge where `insn_ready`, `insn_valid` and opcode `insn_hi[15:12] == 4'b0001` are all true. An instruction with any other opcode produces neither a result nor a memory write.
- R2: For an accepted non-call branch, `res_valid` is high for exactly one cycle, in the cycle after the accepting edge. In that cycle it carries `res_taken` and `res_pc`.
- R3: The displacement is `{insn_hi[7:0], insn_ext}`, sign-extended from bit 23. The taken target is `pc_next` plus this displacement, modulo 2^32.
- R4: The selector is `insn_hi[11:8]` and is decoded as follows:
  - 0000 always branches.
  - 0001, 0010, 0100 and 1000 branch when Zero, Negative, Overflow or Carry is set, respectively.
  - 1110, 1101, 1011 and 0111 branch when that same flag is clear.
- R5: A branch whose condition fails returns `res_taken = 0` and `res_pc = pc_next`. Selector codes not listed in R4 or R6 (for example 0011) always fail.
- R6: Selector 1111 is a subroutine call. It first presents a write of `pc_next[31:16]` to address `sp`, then a write of `pc_next[15:0]` to address `sp + 2`.
- R7: While `mem_wr_valid` is high and `mem_wr_ready` is low, the write address and data stay unchanged in the next cycle.
- R8: A call reports `res_valid` with `res_taken = 1` and the target in the cycle after the second write is acknowledged. `res_valid` is never high while a write is pending.
- R9: `insn_ready` is low from the accepting edge of a call until its result cycle. `insn_valid` is ignored during that time.
- R10: After reset, `res_valid` and `mem_wr_valid` are low and `insn_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| insn_valid | input | 1 | A branch instruction is presented |
| insn_ready | output | 1 | Unit can accept an instruction |
| insn_hi | input | 16 | First instruction word |
| insn_ext | input | 16 | Extension word (low displacement bits) |
| pc_next | input | 32 | Address of the word after the branch |
| sp | input | 32 | Stack pointer for the call store |
| flag_c | input | 1 | Carry flag |
| flag_o | input | 1 | Overflow flag |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| mem_wr_valid | output | 1 | Write request pending |
| mem_wr_ready | input | 1 | Write accepted this cycle |
| mem_wr_addr | output | 32 | Write byte address |
| mem_wr_data | output | 16 | Write data word |
| res_valid | output | 1 | Branch result available (one cycle) |
| res_taken | output | 1 | Branch was taken |
| res_pc | output | 32 | Next program counter value |

## Verification
Two events can fall in the same cycle: the result pulse of one branch and the acceptance of the next. The bench provokes this by holding `insn_valid` high across the whole vector table, so every result cycle is also the cycle in which a fresh instruction is presented. Each result is judged against the expected taken flag and PC of its own vector. A call is also followed immediately by a plain branch, so the call's result cycle is likewise an acceptance cycle.

// File: rtl/bu_pkg.sv
// Shared encodings for the branch unit: opcode, selector codes, FSM states.
package bu_pkg;
    localparam logic [3:0] OPC_BRANCH = 4'b0001;

    localparam logic [3:0] SEL_ALWAYS = 4'b0000;
    localparam logic [3:0] SEL_Z_SET  = 4'b0001;
    localparam logic [3:0] SEL_N_SET  = 4'b0010;
    localparam logic [3:0] SEL_O_SET  = 4'b0100;
    localparam logic [3:0] SEL_C_SET  = 4'b1000;
    localparam logic [3:0] SEL_Z_CLR  = 4'b1110;
    localparam logic [3:0] SEL_N_CLR  = 4'b1101;
    localparam logic [3:0] SEL_O_CLR  = 4'b1011;
    localparam logic [3:0] SEL_C_CLR  = 4'b0111;
    localparam logic [3:0] SEL_CALL   = 4'b1111;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WR_HI = 2'd1,
        ST_WR_LO = 2'd2
    } bu_state_t;
endpackage

// File: rtl/bu_cond_eval.sv
// Condition decoder: maps the 4-bit selector and the flags to a take decision
// and marks the call selector. Purely combinational.
// Assumes: unlisted selector codes are never taken.
module bu_cond_eval
    import bu_pkg::*;
(
    input  logic [3:0] sel,
    input  logic       flag_c,
    input  logic       flag_o,
    input  logic       flag_n,
    input  logic       flag_z,
    output logic       take,
    output logic       is_call
);
    // Decode the selector against the flag set.
    always_comb begin
        take    = 1'b0;
        is_call = 1'b0;
        case (sel)
            SEL_ALWAYS: take = 1'b1;
            SEL_Z_SET:  take = flag_z;
            SEL_N_SET:  take = flag_n;
            SEL_O_SET:  take = flag_o;
            SEL_C_SET:  take = flag_c;
            SEL_Z_CLR:  take = !flag_z;
            SEL_N_CLR:  take = !flag_n;
            SEL_O_CLR:  take = !flag_o;
            SEL_C_CLR:  take = !flag_c;
            SEL_CALL: begin
                take    = 1'b1;
                is_call = 1'b1;
            end
            default:    take = 1'b0;
        endcase
    end
endmodule

// File: rtl/bu_target_add.sv
// Target adder: sign-extends a split displacement and adds it to the base PC.
// Assumes PC_W >= OFF_W; the sum wraps modulo 2**PC_W.
module bu_target_add #(
    parameter int PC_W     = 32,
    parameter int WORD_W   = 16,
    parameter int OFF_HI_W = 8
) (
    input  logic [OFF_HI_W-1:0] off_hi,
    input  logic [WORD_W-1:0]   off_lo,
    input  logic [PC_W-1:0]     base,
    output logic [PC_W-1:0]     target
);
    localparam int OFF_W = OFF_HI_W + WORD_W;
    localparam int EXT_W = PC_W - OFF_W;

    logic [OFF_W-1:0] off;
    logic [PC_W-1:0]  off_sx;

    // Join the displacement halves and sign-extend to PC width.
    always_comb begin
        off    = {off_hi, off_lo};
        off_sx = {{EXT_W{off[OFF_W-1]}}, off};
    end

    // Modular add of base and displacement.
    always_comb target = base + off_sx;
endmodule

// File: rtl/bu_ctrl.sv
// Sequencer: accepts branches, returns results one cycle later, and runs the
// two-write return-address store for calls before reporting the target.
// Assumes PC_W == 2*WORD_W and byte addressing (ADDR_STEP bytes per word).
module bu_ctrl
    import bu_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_ok,
    input  logic              take,
    input  logic              is_call,
    input  logic [PC_W-1:0]   base,
    input  logic [PC_W-1:0]   target,
    input  logic [PC_W-1:0]   sp,
    input  logic              mem_wr_ready,
    output logic              idle,
    output logic              mem_wr_valid,
    output logic [PC_W-1:0]   mem_wr_addr,
    output logic [WORD_W-1:0] mem_wr_data,
    output logic              res_valid,
    output logic              res_taken,
    output logic [PC_W-1:0]   res_pc
);
    localparam int ADDR_STEP = WORD_W / 8;

    bu_state_t          state;
    logic [PC_W-1:0]    ret_q;
    logic [PC_W-1:0]    tgt_q;
    logic [PC_W-1:0]    sp_q;

    // Idle flag and write-port outputs from the current state.
    always_comb begin
        idle         = (state == ST_IDLE);
        mem_wr_valid = (state != ST_IDLE);
        mem_wr_addr  = (state == ST_WR_LO) ? sp_q + PC_W'(ADDR_STEP) : sp_q;
        mem_wr_data  = (state == ST_WR_LO) ? ret_q[WORD_W-1:0]
                                            : ret_q[PC_W-1 -: WORD_W];
    end

    // State sequencing and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ret_q     <= '0;
            tgt_q     <= '0;
            sp_q      <= '0;
            res_valid <= 1'b0;
            res_taken <= 1'b0;
            res_pc    <= '0;
        end else begin
            res_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept_ok) begin
                        if (is_call) begin
                            state <= ST_WR_HI;
                            ret_q <= base;
                            tgt_q <= target;
                            sp_q  <= sp;
                        end else begin
                            res_valid <= 1'b1;
                            res_taken <= take;
                            res_pc    <= take ? target : base;
                        end
                    end
                end
                ST_WR_HI: begin
                    if (mem_wr_ready) state <= ST_WR_LO;
                end
                ST_WR_LO: begin
                    if (mem_wr_ready) begin
                        state     <= ST_IDLE;
                        res_valid <= 1'b1;
                        res_taken <= 1'b1;
                        res_pc    <= tgt_q;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)); // R7
    AST_NO_RES_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> !res_valid); // R8
    AST_CALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_LO) && mem_wr_ready |=> res_valid && res_taken); // R8
    AST_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_WR_LO) |-> $past(state == ST_WR_HI)); // R6
endmodule

// File: rtl/branch_unit.sv
// Top of the conditional PC-relative branch unit. Decodes the opcode, checks
// the condition, forms the target and hands sequencing to bu_ctrl.
// Assumes pc_next is the address following the two-word branch.
module branch_unit
    import bu_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int WORD_W   = 16,
    parameter int OFF_HI_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    output logic              insn_ready,
    input  logic [WORD_W-1:0] insn_hi,
    input  logic [WORD_W-1:0] insn_ext,
    input  logic [PC_W-1:0]   pc_next,
    input  logic [PC_W-1:0]   sp,
    input  logic              flag_c,
    input  logic              flag_o,
    input  logic              flag_n,
    input  logic              flag_z,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [PC_W-1:0]   mem_wr_addr,
    output logic [WORD_W-1:0] mem_wr_data,
    output logic              res_valid,
    output logic              res_taken,
    output logic [PC_W-1:0]   res_pc
);
    localparam int OPC_LSB = WORD_W - 4;
    localparam int SEL_LSB = WORD_W - 8;

    logic            take;
    logic            is_call;
    logic            idle;
    logic            is_branch;
    logic            accept_ok;
    logic [PC_W-1:0] target;

    // Opcode match and acceptance condition.
    always_comb begin
        is_branch  = (insn_hi[OPC_LSB +: 4] == OPC_BRANCH);
        insn_ready = idle;
        accept_ok  = idle && insn_valid && is_branch;
    end

    bu_cond_eval u_cond (
        .sel     (insn_hi[SEL_LSB +: 4]),
        .flag_c  (flag_c),
        .flag_o  (flag_o),
        .flag_n  (flag_n),
        .flag_z  (flag_z),
        .take    (take),
        .is_call (is_call)
    );

    bu_target_add #(.PC_W(PC_W), .WORD_W(WORD_W), .OFF_HI_W(OFF_HI_W)) u_add (
        .off_hi (insn_hi[OFF_HI_W-1:0]),
        .off_lo (insn_ext),
        .base   (pc_next),
        .target (target)
    );

    bu_ctrl #(.PC_W(PC_W), .WORD_W(WORD_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept_ok    (accept_ok),
        .take         (take),
        .is_call      (is_call),
        .base         (pc_next),
        .target       (target),
        .sp           (sp),
        .mem_wr_ready (mem_wr_ready),
        .idle         (idle),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .res_valid    (res_valid),
        .res_taken    (res_taken),
        .res_pc       (res_pc)
    );

    AST_FAIL_KEEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_taken |-> res_pc == $past(pc_next)); // R5
    AST_IGNORE_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        idle && !(insn_valid && is_branch) |=> !res_valid && !mem_wr_valid); // R1
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> !insn_ready); // R9
endmodule

// File: tb/branch_unit_tb.sv
module branch_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;

    typedef struct packed {
        logic [15:0] hi;
        logic [15:0] ext;
        logic [31:0] pc;
        logic [3:0]  flg;     // {c, o, n, z}
        logic        exp_tk;
        logic [31:0] exp_pc;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{16'h1000, 16'h0010, 32'h0000_1000, 4'b0000, 1'b1, 32'h0000_1010}, // R4 always
        '{16'h11FF, 16'hFFFE, 32'h0000_1000, 4'b0001, 1'b1, 32'h0000_0FFE}, // R3 negative
        '{16'h1100, 16'h0020, 32'h0000_1000, 4'b0000, 1'b0, 32'h0000_1000}, // R5 Z clear
        '{16'h1200, 16'h0100, 32'h0000_1000, 4'b0010, 1'b1, 32'h0000_1100}, // R4 N set
        '{16'h1400, 16'h0004, 32'h0000_1000, 4'b0100, 1'b1, 32'h0000_1004}, // R4 O set
        '{16'h1800, 16'h0008, 32'h0000_1000, 4'b1000, 1'b1, 32'h0000_1008}, // R4 C set
        '{16'h1E00, 16'h0008, 32'h0000_1000, 4'b0001, 1'b0, 32'h0000_1000}, // R5 not-Z fails
        '{16'h1E00, 16'h0008, 32'h0000_1000, 4'b0000, 1'b1, 32'h0000_1008}, // R4 not-Z
        '{16'h1D00, 16'h0002, 32'h0000_1000, 4'b0000, 1'b1, 32'h0000_1002}, // R4 not-N
        '{16'h1B00, 16'h0002, 32'h0000_1000, 4'b0100, 1'b0, 32'h0000_1000}, // R5 not-O fails
        '{16'h1700, 16'h0002, 32'h0000_1000, 4'b1000, 1'b0, 32'h0000_1000}, // R5 not-C fails
        '{16'h1300, 16'h0002, 32'h0000_1000, 4'b1111, 1'b0, 32'h0000_1000}, // R5 unlisted
        '{16'h1080, 16'h0000, 32'h0000_1000, 4'b0000, 1'b1, 32'hFF80_1000}, // R3 min disp
        '{16'h107F, 16'hFFFF, 32'hFFFF_FFF0, 4'b0000, 1'b1, 32'h007F_FFEF}, // R3 wrap
        '{16'h1700, 16'h0002, 32'h0000_1000, 4'b0000, 1'b1, 32'h0000_1002}  // R4 not-C
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic        insn_ready;
    logic [15:0] insn_hi = '0;
    logic [15:0] insn_ext = '0;
    logic [31:0] pc_next = '0;
    logic [31:0] sp = '0;
    logic        flag_c = 1'b0, flag_o = 1'b0, flag_n = 1'b0, flag_z = 1'b0;
    logic        mem_wr_valid;
    logic        mem_wr_ready = 1'b0;
    logic [31:0] mem_wr_addr;
    logic [15:0] mem_wr_data;
    logic        res_valid;
    logic        res_taken;
    logic [31:0] res_pc;

    int checks = 0;
    int fails = 0;

    branch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_ready(insn_ready),
        .insn_hi(insn_hi), .insn_ext(insn_ext), .pc_next(pc_next), .sp(sp),
        .flag_c(flag_c), .flag_o(flag_o), .flag_n(flag_n), .flag_z(flag_z),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .res_valid(res_valid), .res_taken(res_taken), .res_pc(res_pc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        insn_hi  = v.hi;
        insn_ext = v.ext;
        pc_next  = v.pc;
        {flag_c, flag_o, flag_n, flag_z} = v.flg;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 res_valid", 64'(res_valid), 64'd0);
        check("R10 mem_wr_valid", 64'(mem_wr_valid), 64'd0);
        check("R10 insn_ready", 64'(insn_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 back-to-back table walk: each result cycle also accepts the next
        insn_valid = 1'b1;
        drive(VECS[0]);
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            check("R2 res_valid", 64'(res_valid), 64'd1);
            check("R4/R5 res_taken", 64'(res_taken), 64'(VECS[i].exp_tk));
            check("R3/R5 res_pc", 64'(res_pc), 64'(VECS[i].exp_pc));
            if (i + 1 < NVEC) drive(VECS[i + 1]);
        end
        // R1: non-branch opcode ignored
        insn_hi = 16'h2000;
        @(negedge clk);
        check("R1 other opcode res", 64'(res_valid), 64'd0);
        check("R1 other opcode wr", 64'(mem_wr_valid), 64'd0);
        insn_valid = 1'b0;
        insn_hi = 16'h1000;
        @(negedge clk);
        check("R1 invalid ignored", 64'(res_valid), 64'd0);

        // R6 call sequence
        insn_valid = 1'b1;
        insn_hi = 16'h1F00; insn_ext = 16'h0040;
        pc_next = 32'h1234_5678; sp = 32'h0000_8000;
        @(negedge clk);
        // R9: a plain branch presented while busy must be ignored
        insn_hi = 16'h1000; insn_ext = 16'h0004; pc_next = 32'h0000_2000;
        check("R6 wr valid hi", 64'(mem_wr_valid), 64'd1);
        check("R6 wr addr hi", 64'(mem_wr_addr), 64'h8000);
        check("R6 wr data hi", 64'(mem_wr_data), 64'h1234);
        check("R9 not ready", 64'(insn_ready), 64'd0);
        @(negedge clk);
        check("R7 hold addr", 64'(mem_wr_addr), 64'h8000);
        check("R7 hold data", 64'(mem_wr_data), 64'h1234);
        check("R8 no early res", 64'(res_valid), 64'd0);
        mem_wr_ready = 1'b1;
        @(negedge clk);
        check("R6 wr addr lo", 64'(mem_wr_addr), 64'h8002);
        check("R6 wr data lo", 64'(mem_wr_data), 64'h5678);
        check("R9 ignored while busy", 64'(res_valid), 64'd0);
        @(negedge clk);
        mem_wr_ready = 1'b0;
        check("R8 call res_valid", 64'(res_valid), 64'd1);
        check("R8 call taken", 64'(res_taken), 64'd1);
        check("R8 call target", 64'(res_pc), 64'h1234_56B8);
        check("R8 write done", 64'(mem_wr_valid), 64'd0);
        // the still-presented branch is accepted in the call's result cycle
        @(negedge clk);
        insn_valid = 1'b0;
        check("R2 after call res", 64'(res_valid), 64'd1);
        check("R2 after call pc", 64'(res_pc), 64'h0000_2004);
        @(negedge clk);
        check("R2 single pulse", 64'(res_valid), 64'd0);
        finish_run();
    end
endmodule